// File: doc/BRIEF.md
# SAR ADC Serial Readout Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a serial output and runs from a clock supplied by the host. On a request it lowers the chip-select line first and then the convert-start line, keeping each of them within the analog minimum widths. It then watches the converter's active-low busy line go low and come back high. Only after that does it produce a burst of data-clock pulses and shift the result in, most significant bit first. The data clock stays low for the whole conversion, so no digital edge disturbs the analog decision. The word is always the result of the conversion that has just finished.

An optional framing mode is chosen per request. In this mode one data-clock pulse is issued while both strobes are low, which arms the converter's frame-marker output. The read burst then carries one extra pulse, and the controller checks the marker before it takes in the data bits. Each completed word is presented with a one-cycle valid strobe. The first word after reset is flagged, because the converter's first result is not trustworthy. A missing busy edge ends the transaction with a timeout pulse. A missing frame marker ends it with a framing error, and in both cases no word is produced. All widths, setup delays, the data-clock half period and both timeout limits are counts of the system clock.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, chip-select and convert-start are high, the data clock is low, `sample_valid`, `timeout_err` and `sync_err` are low, and `ctrl_idle` is high.
- R2: On an accepted request, `adc_cs_n` falls first. `adc_convst_n` falls at least GAP_CYC cycles later and stays low for at least LOW_CYC cycles. It then returns high while `adc_cs_n` stays low.
- R3: From the moment convert-start returns high until busy has been seen high again, the data clock stays low. During the read burst, chip-select is low and convert-start is high.
- R4: Every high phase and every low phase of the data clock lasts at least HALF_CYC system cycles.
- R5: Without framing, the burst has exactly DATA_W+1 pulses. Data is sampled at the rising edges of pulses 2 through DATA_W+1. The bit taken at pulse 2 is bit DATA_W-1 (the MSB), and the bit taken at the last pulse is bit 0.
- R6: With framing, one data-clock pulse is issued while both strobes are low. The read burst then has DATA_W+2 pulses, and data is sampled at the rising edges of pulses 3 through DATA_W+2, MSB first. Counting the arming pulse, a framed transaction therefore has DATA_W+3 pulses.
- R7: A successful read raises `sample_valid` for exactly one cycle with the word on `sample_data`. `adc_cs_n` returns high in that same cycle, and the controller is idle in the next cycle.
- R8: `sample_first` is high together with the first `sample_valid` after reset and low on all later ones. Transactions that end in an error do not clear this flag.
- R9: If busy has not been seen low within BUSY_LO_TO cycles after convert-start returns high, `timeout_err` pulses for one cycle, chip-select returns high, and no word is presented.
- R10: If busy has not been seen high again within BUSY_HI_TO cycles after it was seen low, `timeout_err` pulses for one cycle, chip-select returns high, and no word is presented.
- R11: In framing mode, if the frame-marker input is low at the rising edge of read pulse 2, the transaction ends with a one-cycle `sync_err` and no `sample_valid`.
- R12: A request that arrives while a transaction is in progress is ignored. It starts no second conversion, either during the transaction or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Request one conversion; accepted only when idle |
| sync_en | input | 1 | Framing mode for this request, sampled together with `conv_req` |
| adc_busy_n | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_sdata | input | 1 | Converter serial data |
| adc_sync | input | 1 | Converter frame-marker output |
| adc_cs_n | output | 1 | Chip-select to the converter, active low |
| adc_convst_n | output | 1 | Convert-start to the converter, active low |
| adc_sclk | output | 1 | Gated data clock to the converter |
| ctrl_idle | output | 1 | High when a new request can be accepted |
| sample_valid | output | 1 | One-cycle strobe for a completed word |
| sample_data | output | DATA_W | Last word read |
| sample_first | output | 1 | Marks the first word after reset |
| timeout_err | output | 1 | One-cycle pulse when a busy edge is missing |
| sync_err | output | 1 | One-cycle pulse when the frame marker is missing |

## Verification
Several properties are checked on every cycle:
- the chip-select to convert-start spacing and the convert-start low width, both measured with counters;
- the minimum width of each data-clock phase;
- the data clock held low while busy is pending;
- the strobe levels during the read burst;
- the one-cycle shape of the valid strobe, and the exclusion of valid by either error.

Only the bench's scenarios can show that the right bits arrive in the right order. The same holds for the exact pulse count of plain and framed transactions, the first-word flag and its survival across failed transactions, and the recovery after each timeout. Those scenarios also show that a request made mid-transaction starts nothing.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CSSET = 3'd1,
        ST_CONV  = 3'd2,
        ST_BLO   = 3'd3,
        ST_BHI   = 3'd4,
        ST_READ  = 3'd5
    } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous level input.
module adc_rd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/adc_rd_sclkgen.sv
`timescale 1ns/1ps
// Gated data-clock divider; reports the cycle in which each edge is launched.
module adc_rd_sclkgen #(
    parameter int HALF_CYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] CNT_END = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic at_end;

    always_comb begin
        at_end = (gen_q.cnt == CNT_END);
        rise   = en && at_end && !gen_q.sclk;
        fall   = en && at_end && gen_q.sclk;
        gen_d  = gen_q;
        if (!en) begin
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b0;
        end else if (at_end) begin
            gen_d.cnt  = '0;
            gen_d.sclk = !gen_q.sclk;
        end else begin
            gen_d.cnt  = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk = gen_q.sclk;
endmodule

// File: rtl/adc_rd_shreg.sv
`timescale 1ns/1ps
// MSB-first capture register.
module adc_rd_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr)        q_d = '0;
        else if (shift) q_d = {q_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
// Host-side conversion and serial readout sequencer.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int HALF_CYC    = 9,
    parameter int GAP_CYC     = 3,
    parameter int LOW_CYC     = 13,
    parameter int BUSY_LO_TO  = 32,
    parameter int BUSY_HI_TO  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_req,
    input  logic              sync_en,
    input  logic              adc_busy_n,
    input  logic              adc_sdata,
    input  logic              adc_sync,
    output logic              adc_cs_n,
    output logic              adc_convst_n,
    output logic              adc_sclk,
    output logic              ctrl_idle,
    output logic              sample_valid,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_first,
    output logic              timeout_err,
    output logic              sync_err
);
    localparam int TMAX_A = (BUSY_HI_TO > BUSY_LO_TO) ? BUSY_HI_TO : BUSY_LO_TO;
    localparam int TMAX_B = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int NPW    = $clog2(DATA_W + 3);

    localparam logic [TW-1:0]  GAP_END  = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0]  LOW_END  = TW'(LOW_CYC - 1);
    localparam logic [TW-1:0]  BLO_END  = TW'(BUSY_LO_TO - 1);
    localparam logic [TW-1:0]  BHI_END  = TW'(BUSY_HI_TO - 1);
    localparam logic [NPW-1:0] LAST_P   = NPW'(DATA_W + 1);
    localparam logic [NPW-1:0] LAST_S   = NPW'(DATA_W + 2);
    localparam logic [NPW-1:0] PLS_MARK = NPW'(2);
    localparam logic [NPW-1:0] PLS_D_P  = NPW'(2);
    localparam logic [NPW-1:0] PLS_D_S  = NPW'(3);

    typedef struct packed {
        rd_state_e      st;
        logic           cs_n;
        logic           cv_n;
        logic           smode;
        logic           p0_done;
        logic [TW-1:0]  tmr;
        logic [NPW-1:0] npls;
        logic           first_pend;
        logic           sbad;
        logic           vld;
        logic           first_o;
        logic           tout;
        logic           serr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, cs_n: 1'b1, cv_n: 1'b1, smode: 1'b0, p0_done: 1'b0,
        tmr: '0, npls: '0, first_pend: 1'b1, sbad: 1'b0, vld: 1'b0,
        first_o: 1'b0, tout: 1'b0, serr: 1'b0
    };

    ctl_t r_d, r_q;
    logic busy_s;
    logic sclk_en, sc_rise, sc_fall;
    logic sh_clr, sh_en;
    logic [NPW-1:0] pnum;

    adc_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bsync (
        .clk(clk), .rst_n(rst_n), .din(adc_busy_n), .dout(busy_s)
    );

    adc_rd_sclkgen #(.HALF_CYC(HALF_CYC)) u_sclk (
        .clk(clk), .rst_n(rst_n), .en(sclk_en),
        .sclk(adc_sclk), .rise(sc_rise), .fall(sc_fall)
    );

    adc_rd_shreg #(.W(DATA_W)) u_shr (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift(sh_en),
        .din(adc_sdata), .q(sample_data)
    );

    always_comb begin
        r_d         = r_q;
        r_d.vld     = 1'b0;
        r_d.tout    = 1'b0;
        r_d.serr    = 1'b0;
        r_d.first_o = 1'b0;
        if (r_q.tmr != '1) r_d.tmr = r_q.tmr + 1'b1;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        pnum    = r_q.npls + 1'b1;
        sclk_en = ((r_q.st == ST_CONV) && r_q.smode && !r_q.p0_done)
                || (r_q.st == ST_READ);

        case (r_q.st)
            ST_IDLE: begin
                if (conv_req) begin
                    r_d.st      = ST_CSSET;
                    r_d.cs_n    = 1'b0;
                    r_d.smode   = sync_en;
                    r_d.p0_done = 1'b0;
                    r_d.sbad    = 1'b0;
                    r_d.tmr     = '0;
                end
            end
            ST_CSSET: begin
                if (r_q.tmr >= GAP_END) begin
                    r_d.st   = ST_CONV;
                    r_d.cv_n = 1'b0;
                    r_d.tmr  = '0;
                end
            end
            ST_CONV: begin
                if (sc_fall) r_d.p0_done = 1'b1;
                if ((r_q.tmr >= LOW_END) && (!r_q.smode || r_q.p0_done)) begin
                    r_d.st   = ST_BLO;
                    r_d.cv_n = 1'b1;
                    r_d.tmr  = '0;
                end
            end
            ST_BLO: begin
                if (!busy_s) begin
                    r_d.st  = ST_BHI;
                    r_d.tmr = '0;
                end else if (r_q.tmr >= BLO_END) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    r_d.tout = 1'b1;
                end
            end
            ST_BHI: begin
                if (busy_s) begin
                    r_d.st   = ST_READ;
                    r_d.npls = '0;
                    r_d.tmr  = '0;
                    sh_clr   = 1'b1;
                end else if (r_q.tmr >= BHI_END) begin
                    r_d.st   = ST_IDLE;
                    r_d.cs_n = 1'b1;
                    r_d.tout = 1'b1;
                end
            end
            ST_READ: begin
                if (sc_rise) begin
                    r_d.npls = pnum;
                    if (r_q.smode) begin
                        if ((pnum == PLS_MARK) && !adc_sync) r_d.sbad = 1'b1;
                        sh_en = (pnum >= PLS_D_S);
                    end else begin
                        sh_en = (pnum >= PLS_D_P);
                    end
                end
                if (sc_fall && (r_q.npls == (r_q.smode ? LAST_S : LAST_P))) begin
                    r_d.st      = ST_IDLE;
                    r_d.cs_n    = 1'b1;
                    r_d.vld     = !r_q.sbad;
                    r_d.serr    = r_q.sbad;
                    r_d.first_o = r_q.first_pend && !r_q.sbad;
                    if (!r_q.sbad) r_d.first_pend = 1'b0;
                end
            end
            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign adc_cs_n     = r_q.cs_n;
    assign adc_convst_n = r_q.cv_n;
    assign ctrl_idle    = (r_q.st == ST_IDLE);
    assign sample_valid = r_q.vld;
    assign sample_first = r_q.first_o;
    assign timeout_err  = r_q.tout;
    assign sync_err     = r_q.serr;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker attached to adc_rd_ctrl.
module adc_rd_ctrl_chk
    import adc_rd_pkg::*;
#(
    parameter int HALF_CYC = 9,
    parameter int GAP_CYC  = 3,
    parameter int LOW_CYC  = 13
) (
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      convst_n,
    input logic      sclk,
    input rd_state_e st,
    input logic      sample_valid,
    input logic      timeout_err,
    input logic      sync_err
);
    logic [15:0] cs_lo_cnt, cv_lo_cnt, stab_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_lo_cnt <= '0;
            cv_lo_cnt <= '0;
            stab_cnt  <= '0;
        end else begin
            cs_lo_cnt <= cs_n ? '0 : ((cs_lo_cnt != '1) ? cs_lo_cnt + 1'b1 : cs_lo_cnt);
            cv_lo_cnt <= convst_n ? '0 : ((cv_lo_cnt != '1) ? cv_lo_cnt + 1'b1 : cv_lo_cnt);
            stab_cnt  <= (sclk != $past(sclk)) ? 16'd1
                       : ((stab_cnt != '1) ? stab_cnt + 1'b1 : stab_cnt);
        end
    end

    // R2
    strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_n) |-> (!cs_n && (cs_lo_cnt >= 16'(GAP_CYC))));

    // R2
    convst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_n) |-> (cv_lo_cnt >= 16'(LOW_CYC)) && !cs_n);

    // R3
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BHI) |-> !sclk);

    // R3
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ) |-> (!cs_n && convst_n));

    // R4
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> (stab_cnt >= 16'(HALF_CYC)));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7
    valid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> cs_n);

    // R9
    timeout_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (cs_n && convst_n && !sample_valid));

    // R11
    sync_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !sample_valid);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC), .LOW_CYC(LOW_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .convst_n(adc_convst_n),
    .sclk(adc_sclk), .st(r_q.st), .sample_valid(sample_valid),
    .timeout_err(timeout_err), .sync_err(sync_err)
);

// File: tb/adc_rd_ctrl_test.sv
`timescale 1ns/1ps
module adc_rd_ctrl_test;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_req = 1'b0;
    logic sync_en = 1'b0;
    logic adc_busy_n = 1'b1;
    logic adc_sdata = 1'b0;
    logic adc_sync = 1'b0;
    logic adc_cs_n, adc_convst_n, adc_sclk, ctrl_idle;
    logic sample_valid, sample_first, timeout_err, sync_err;
    logic [DW-1:0] sample_data;

    always #2 clk = ~clk;

    adc_rd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .sync_en(sync_en),
        .adc_busy_n(adc_busy_n), .adc_sdata(adc_sdata), .adc_sync(adc_sync),
        .adc_cs_n(adc_cs_n), .adc_convst_n(adc_convst_n), .adc_sclk(adc_sclk),
        .ctrl_idle(ctrl_idle), .sample_valid(sample_valid), .sample_data(sample_data),
        .sample_first(sample_first), .timeout_err(timeout_err), .sync_err(sync_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // ---------------- converter model ----------------
    logic          mdl_no_busy = 1'b0;
    logic          mdl_stuck   = 1'b0;
    logic          mdl_no_sync = 1'b0;
    logic [DW-1:0] mdl_word    = '0;
    logic [DW-1:0] cur_word    = '0;
    int            rcnt        = 0;
    logic          sync_arm    = 1'b0;

    always @(negedge adc_convst_n) begin
        if (!adc_cs_n && !mdl_no_busy) begin
            #20 adc_busy_n = 1'b0;
            if (mdl_stuck) wait (!mdl_stuck);
            else #1000;
            cur_word   = mdl_word;
            adc_busy_n = 1'b1;
        end
    end

    always @(posedge adc_sclk) begin
        if (!adc_cs_n) begin
            if (!adc_convst_n) begin
                sync_arm = 1'b1;
            end else if (adc_busy_n) begin
                rcnt = rcnt + 1;
                if (sync_arm) begin
                    if (rcnt == 1) adc_sync <= #10 !mdl_no_sync;
                    else if (rcnt >= 2 && rcnt <= DW + 1) begin
                        adc_sync  <= #10 1'b0;
                        adc_sdata <= #10 cur_word[DW + 1 - rcnt];
                    end else adc_sdata <= #10 1'b0;
                end else begin
                    if (rcnt >= 1 && rcnt <= DW) adc_sdata <= #10 cur_word[DW - rcnt];
                    else adc_sdata <= #10 1'b0;
                end
            end
        end
    end

    always @(posedge adc_cs_n) begin
        rcnt     = 0;
        sync_arm = 1'b0;
        adc_sync <= 1'b0;
    end

    // ---------------- monitors ----------------
    int      n_rise = 0, n_rise_busy = 0, n_cvfall = 0;
    realtime t_csf = 0, t_cvf = 0, last_gap = 0, last_low = 0;
    realtime t_r = 0, t_f = 0, min_hi = 1.0e9, min_lo = 1.0e9;

    always @(posedge adc_sclk) begin
        n_rise = n_rise + 1;
        if (!adc_busy_n) n_rise_busy = n_rise_busy + 1;
        t_r = $realtime;
        if (t_f > 0 && (t_r - t_f) < min_lo) min_lo = t_r - t_f;
    end
    always @(negedge adc_sclk) begin
        t_f = $realtime;
        if ((t_f - t_r) < min_hi) min_hi = t_f - t_r;
    end
    always @(negedge adc_cs_n) t_csf = $realtime;
    always @(negedge adc_convst_n) begin
        n_cvfall = n_cvfall + 1;
        t_cvf    = $realtime;
        last_gap = t_cvf - t_csf;
    end
    always @(posedge adc_convst_n) last_low = $realtime - t_cvf;

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic          g_vld, g_first, g_tout, g_serr, g_idle, g_csn;
    logic [DW-1:0] g_data;

    task automatic run_conv(input logic smode, input logic [DW-1:0] w, input logic extra_req);
        mdl_word    = w;
        n_rise      = 0;
        n_rise_busy = 0;
        n_cvfall    = 0;
        g_vld = 0; g_first = 0; g_tout = 0; g_serr = 0; g_data = '0;
        @(negedge clk);
        conv_req = 1'b1;
        sync_en  = smode;
        @(negedge clk);
        conv_req = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            conv_req = extra_req && (i == 100 || i == 101);
            if (sample_valid || timeout_err || sync_err) begin
                g_vld   = sample_valid;
                g_first = sample_first;
                g_tout  = timeout_err;
                g_serr  = sync_err;
                g_data  = sample_data;
                g_csn   = adc_cs_n;
                break;
            end
        end
        conv_req = 1'b0;
        @(negedge clk);
        g_idle = ctrl_idle && !sample_valid;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "cs_n", adc_cs_n, 1);
        chk("R1", "convst_n", adc_convst_n, 1);
        chk("R1", "sclk", adc_sclk, 0);
        chk("R1", "idle", ctrl_idle, 1);
        chk("R1", "valid", sample_valid, 0);
        chk("R1", "errors", {timeout_err, sync_err}, 0);
    endtask

    task automatic t_tout_lo();
        mdl_no_busy = 1'b1;
        run_conv(1'b0, 16'h1111, 1'b0);
        mdl_no_busy = 1'b0;
        chk("R9", "timeout pulse", g_tout, 1);
        chk("R9", "no valid", g_vld, 0);
        chk("R9", "cs released", g_csn, 1);
        chk("R9", "idle after", g_idle, 1);
        chk("R9", "no data clock", n_rise, 0);
    endtask

    task automatic t_plain(input logic [DW-1:0] w, input logic exp_first);
        run_conv(1'b0, w, 1'b0);
        chk("R5", "word", g_data, w);
        chk("R5", "pulse count", n_rise, DW + 1);
        chk("R7", "valid", g_vld, 1);
        chk("R7", "cs high with valid", g_csn, 1);
        chk("R7", "idle next cycle", g_idle, 1);
        chk("R8", "first flag", g_first, exp_first);
        chk("R3", "no clock while busy", n_rise_busy, 0);
        chk("R2", "cs-to-convst gap ok", (last_gap >= 12.0), 1);
        chk("R2", "convst low width ok", (last_low >= 52.0), 1);
    endtask

    task automatic t_sync(input logic [DW-1:0] w);
        run_conv(1'b1, w, 1'b0);
        chk("R6", "word", g_data, w);
        chk("R6", "pulse count", n_rise, DW + 3);
        chk("R6", "valid", g_vld, 1);
        chk("R6", "no sync error", g_serr, 0);
        chk("R8", "first flag low", g_first, 0);
    endtask

    task automatic t_half();
        chk("R4", "min high phase", (min_hi >= 36.0), 1);
        chk("R4", "min low phase", (min_lo >= 36.0), 1);
    endtask

    task automatic t_req_ignored();
        run_conv(1'b0, 16'h3C5A, 1'b1);
        chk("R12", "word", g_data, 16'h3C5A);
        chk("R12", "single convst", n_cvfall, 1);
        repeat (60) @(negedge clk);
        chk("R12", "still idle", ctrl_idle, 1);
        chk("R12", "cs high", adc_cs_n, 1);
        chk("R12", "no later convst", n_cvfall, 1);
    endtask

    task automatic t_tout_hi();
        mdl_stuck = 1'b1;
        run_conv(1'b0, 16'h2222, 1'b0);
        chk("R10", "timeout pulse", g_tout, 1);
        chk("R10", "no valid", g_vld, 0);
        chk("R10", "cs released", g_csn, 1);
        chk("R10", "no data clock", n_rise, 0);
        mdl_stuck = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10", "idle after", ctrl_idle, 1);
    endtask

    task automatic t_sync_missing();
        mdl_no_sync = 1'b1;
        run_conv(1'b1, 16'h4444, 1'b0);
        mdl_no_sync = 1'b0;
        chk("R11", "sync error", g_serr, 1);
        chk("R11", "no valid", g_vld, 0);
        chk("R11", "idle after", g_idle, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_tout_lo();
        t_plain(16'hA5C3, 1'b1);
        t_plain(16'h0001, 1'b0);
        t_plain(16'hFFFF, 1'b0);
        t_plain(16'h8000, 1'b0);
        t_sync(16'h1234);
        t_sync(16'h7FFE);
        t_half();
        t_req_ignored();
        t_tout_hi();
        t_sync_missing();
        t_plain(16'h0F0F, 1'b0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule